// File: doc/BRIEF.md
# Selectable-Period Interrupt Pulse Generator

This block turns the timing strobes of a calendar clock into one periodic event output. Four single-cycle strobes come in: a 64 Hz base tick and the seconds, minutes and hours carries. A 4-bit control register picks which strobe counts as a period event. The same register sets whether the output is masked, and whether the output behaves as a latched interrupt or as a standard pulse of fixed width.

Each period event sets an interrupt flag. The flag sits at bit 2 of a separate 4-bit status/control register. Software clears it by writing that bit as 0. Writing the bit as 1 leaves the flag alone, so software can write the rest of that register without losing a pending event.

The event output is active-low and idles at 1, in the manner of an open-drain line. When the period field changes, event detection restarts, so the first event that follows is never a partial period.

Top module: `period_irq_gen`

## Requirements
- R1: After reset, the control register reads 4'b0001 (masked, pulse mode, 1/64 s period), the flag reads 0 and the event output is 1.
- R2: Control bits 3:2 select the event source: 00 is the 64 Hz tick, 01 the seconds carry, 10 the minutes carry and 11 the hours carry. Strobes of the sources that are not selected have no effect on the flag or the output.
- R3: When detection is armed, a selected strobe in one cycle sets the flag, visible on the flag output from the next cycle onward.
- R4: A status write whose bit 2 is 0 clears the flag from the next cycle. A status write whose bit 2 is 1 leaves the flag unchanged.
- R5: When a period event and a clearing status write fall in the same cycle, the flag ends up set.
- R6: With control bit 1 = 1 (interrupt mode) and the mask clear, the event output is 0 exactly while the flag is 1.
- R7: With control bit 1 = 0 (pulse mode) and the mask clear, each event drives the output to 0 for exactly PULSE_CYCLES cycles, starting in the cycle after the event, whatever the flag does. An event during a pulse restarts the count.
- R8: With control bit 0 = 1 (mask), the event output stays 1 in both modes, while the flag still sets on events.
- R9: After reset, and after any control write that changes bits 3:2, the first strobe of the selected source only arms detection and sets nothing. A strobe in the cycle of such a write is ignored. A control write that keeps bits 3:2 does not disarm.
- R10: A control write takes effect on the control readback in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_64hz_i | input | 1 | 64 Hz base tick strobe |
| sec_carry_i | input | 1 | Seconds carry strobe |
| min_carry_i | input | 1 | Minutes carry strobe |
| hour_carry_i | input | 1 | Hours carry strobe |
| ctl_we_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | 4 | Control write data: [3:2] period, [1] interrupt mode, [0] mask |
| stat_we_i | input | 1 | Status register write enable |
| stat_wdata_i | input | 4 | Status write data; bit 2 = 0 clears the flag |
| ctl_o | output | 4 | Control register readback |
| flag_o | output | 1 | Interrupt flag (status bit 2) |
| irq_n_o | output | 1 | Event output, active low |

## Verification
A flag that sets or clears wrongly shows on flag_o one cycle after the strobe or write that caused it. In interrupt mode it also shows on irq_n_o in that same cycle. A wrong arming state shows as a missing first or second event after a period change. A wrong pulse counter shows as a low phase one cycle too short or too long on irq_n_o, visible within PULSE_CYCLES+1 cycles of the event. The bench compares all three outputs against its own model every cycle, so any of these faults is reported in the cycle where it first appears.

// File: rtl/period_irq_pkg.sv
package period_irq_pkg;

    typedef enum logic [1:0] {
        PER_TICK = 2'b00,
        PER_SEC  = 2'b01,
        PER_MIN  = 2'b10,
        PER_HOUR = 2'b11
    } period_e;

    typedef struct packed {
        period_e period;
        logic    int_mode;
        logic    mask;
    } ctl_t;

    localparam int NUM_SRC = 4;
    localparam int FLAG_BIT = 2;
    localparam ctl_t CTL_RESET = '{period: PER_TICK, int_mode: 1'b0, mask: 1'b1};

endpackage

// File: rtl/period_irq_evsel.sv
module period_irq_evsel
    import period_irq_pkg::*;
#(
    parameter int SRC_N = NUM_SRC,
    localparam int SELW = $clog2(SRC_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] strobe_i,
    input  logic [SELW-1:0]  sel_i,
    input  logic             restart_i,
    output logic             fire_o,
    output logic             armed_o
);

    typedef struct packed {
        logic armed;
    } st_t;

    st_t st_d, st_q;
    logic [SRC_N-1:0] hit;
    logic             ev;

    for (genvar g = 0; g < SRC_N; g++) begin : g_hit
        assign hit[g] = strobe_i[g] && (sel_i == SELW'(g));
    end

    assign ev = |hit;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        if (restart_i) begin
            st_d.armed = 1'b0;
        end else if (ev) begin
            fire_o     = st_q.armed;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o = st_q.armed;

endmodule

// File: rtl/period_irq_flag.sv
module period_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/period_irq_pulse.sv
module period_irq_pulse #(
    parameter int PULSE_CYCLES = 4,
    localparam int CW = $clog2(PULSE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.cnt = CW'(PULSE_CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.cnt != '0);

endmodule

// File: rtl/period_irq_gen.sv
module period_irq_gen
    import period_irq_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_64hz_i,
    input  logic       sec_carry_i,
    input  logic       min_carry_i,
    input  logic       hour_carry_i,
    input  logic       ctl_we_i,
    input  logic [3:0] ctl_wdata_i,
    input  logic       stat_we_i,
    input  logic [3:0] stat_wdata_i,
    output logic [3:0] ctl_o,
    output logic       flag_o,
    output logic       irq_n_o
);

    typedef struct packed {
        ctl_t ctl;
    } st_t;

    st_t st_d, st_q;

    ctl_t       wr_ctl;
    logic       restart;
    logic       fire;
    logic       armed;
    logic       clr_req;
    logic       pulse_act;
    logic       drive_low;
    logic [NUM_SRC-1:0] strobes;

    assign wr_ctl  = ctl_t'(ctl_wdata_i);
    assign strobes = {hour_carry_i, min_carry_i, sec_carry_i, tick_64hz_i};

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        if (ctl_we_i) begin
            st_d.ctl = wr_ctl;
            restart  = (wr_ctl.period != st_q.ctl.period);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl <= CTL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    period_irq_evsel #(.SRC_N(NUM_SRC)) u_evsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (strobes),
        .sel_i     (st_q.ctl.period),
        .restart_i (restart),
        .fire_o    (fire),
        .armed_o   (armed)
    );

    assign clr_req = stat_we_i && !stat_wdata_i[FLAG_BIT];

    period_irq_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fire),
        .clr_i  (clr_req),
        .flag_o (flag_o)
    );

    period_irq_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (fire),
        .active_o (pulse_act)
    );

    always_comb begin
        drive_low = 1'b0;
        if (!st_q.ctl.mask) begin
            drive_low = st_q.ctl.int_mode ? flag_o : pulse_act;
        end
    end

    assign irq_n_o = !drive_low;
    assign ctl_o   = st_q.ctl;

endmodule

// File: rtl/period_irq_gen_chk.sv
module period_irq_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we_i,
    input logic [3:0] ctl_wdata_i,
    input logic       stat_we_i,
    input logic [3:0] stat_wdata_i,
    input logic [3:0] ctl_o,
    input logic       flag_o,
    input logic       irq_n_o,
    input logic       fire
);

    a_r5_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag_o);

    a_r4_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we_i && !stat_wdata_i[2] && !fire) |=> !flag_o);

    a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(stat_we_i && !stat_wdata_i[2])) |=> flag_o);

    a_r8_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o[0] |-> irq_n_o);

    a_r6_int_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[1] && !ctl_o[0]) |-> (irq_n_o == !flag_o));

    a_r7_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ctl_o[1] && !ctl_o[0] && !ctl_we_i) |=> !irq_n_o);

    a_r9_change_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && (ctl_wdata_i[3:2] != ctl_o[3:2])) |=> !$rose(flag_o));

    a_r10_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we_i |=> (ctl_o == $past(ctl_wdata_i)));

endmodule

bind period_irq_gen period_irq_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_we_i     (ctl_we_i),
    .ctl_wdata_i  (ctl_wdata_i),
    .stat_we_i    (stat_we_i),
    .stat_wdata_i (stat_wdata_i),
    .ctl_o        (ctl_o),
    .flag_o       (flag_o),
    .irq_n_o      (irq_n_o),
    .fire         (fire)
);

// File: tb/test_period_irq_gen.sv
module test_period_irq_gen;

    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, sec = 1'b0, mnt = 1'b0, hr = 1'b0;
    logic       ctl_we = 1'b0, stat_we = 1'b0;
    logic [3:0] ctl_wd = '0, stat_wd = '0;
    logic [3:0] ctl_o;
    logic       flag_o, irq_n_o;

    int n_chk = 0, n_fail = 0;

    logic [3:0] m_ctl;
    logic       m_flag, m_armed;
    int         m_cnt;

    always #2 clk = ~clk;

    period_irq_gen #(.PULSE_CYCLES(P)) i_period_irq_gen (
        .clk(clk), .rst_n(rst_n),
        .tick_64hz_i(tick), .sec_carry_i(sec), .min_carry_i(mnt), .hour_carry_i(hr),
        .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
        .stat_we_i(stat_we), .stat_wdata_i(stat_wd),
        .ctl_o(ctl_o), .flag_o(flag_o), .irq_n_o(irq_n_o)
    );

    function automatic logic src_hit(logic [1:0] per, logic t, logic s, logic m, logic h);
        case (per)
            2'b00: return t;
            2'b01: return s;
            2'b10: return m;
            default: return h;
        endcase
    endfunction

    function automatic logic exp_irq_n(logic [3:0] c, logic f, int cnt);
        if (c[0]) return 1'b1;
        if (c[1]) return !f;
        return !(cnt != 0);
    endfunction

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ctl = 4'b0001; m_flag = 1'b0; m_armed = 1'b0; m_cnt = 0;
    endtask

    task automatic model_step();
        logic ev, chg, fire;
        ev   = src_hit(m_ctl[3:2], tick, sec, mnt, hr);
        chg  = ctl_we && (ctl_wd[3:2] != m_ctl[3:2]);
        fire = ev && m_armed && !chg;
        if (chg) m_armed = 1'b0; else if (ev) m_armed = 1'b1;
        if (fire) m_flag = 1'b1;
        else if (stat_we && !stat_wd[2]) m_flag = 1'b0;
        if (fire) m_cnt = P; else if (m_cnt != 0) m_cnt--;
        if (ctl_we) m_ctl = ctl_wd;
    endtask

    task automatic compare_all();
        check("R10 ctl", ctl_o, m_ctl);
        check("R3/R4 flag", flag_o, m_flag);
        if (m_ctl[0]) check("R8 irq_n", irq_n_o, 1);
        else if (m_ctl[1]) check("R6 irq_n", irq_n_o, exp_irq_n(m_ctl, m_flag, m_cnt));
        else check("R7 irq_n", irq_n_o, exp_irq_n(m_ctl, m_flag, m_cnt));
    endtask

    // inputs are set just after a negedge; one clock edge; outputs compared at next negedge
    task automatic cyc(logic t, logic s, logic m, logic h,
                       logic cwe, logic [3:0] cwd, logic swe, logic [3:0] swd);
        tick = t; sec = s; mnt = m; hr = h;
        ctl_we = cwe; ctl_wd = cwd; stat_we = swe; stat_wd = swd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        tick = 0; sec = 0; mnt = 0; hr = 0; ctl_we = 0; stat_we = 0;
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 4'h0, 0, 4'h0);
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ctl", ctl_o, 4'b0001);
        check("R1 flag", flag_o, 0);
        check("R1 irq_n", irq_n_o, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R9: select seconds, interrupt mode, unmasked
        cyc(0, 0, 0, 0, 1, 4'b0110, 0, 4'h0);
        cyc(0, 1, 0, 0, 0, 4'h0, 0, 4'h0);       // arms only (R9)
        check("R9 first event arms only", flag_o, 0);
        cyc(1, 0, 1, 1, 0, 4'h0, 0, 4'h0);       // other sources
        check("R2 unselected ignored", flag_o, 0);
        check("R2 irq_n quiet", irq_n_o, 1);
        cyc(0, 1, 0, 0, 0, 4'h0, 0, 4'h0);
        check("R3 flag set", flag_o, 1);
        check("R6 irq_n low", irq_n_o, 0);
        cyc(0, 0, 0, 0, 0, 4'h0, 1, 4'b1111);
        check("R4 write one keeps", flag_o, 1);
        cyc(0, 0, 0, 0, 0, 4'h0, 1, 4'b1011);
        check("R4 write zero clears", flag_o, 0);
        check("R6 irq_n released", irq_n_o, 1);
        // R5: event and clear together
        cyc(0, 1, 0, 0, 0, 4'h0, 1, 4'b0000);
        check("R5 event wins", flag_o, 1);
        // R9: same-period write keeps arming, mode change to pulse
        cyc(0, 0, 0, 0, 1, 4'b0100, 1, 4'b0000);
        cyc(0, 1, 0, 0, 0, 4'h0, 0, 4'h0);
        check("R9 same period stays armed", flag_o, 1);
        for (int i = 0; i < P; i++) begin
            check("R7 pulse low", irq_n_o, 0);
            cyc(0, 0, 0, 0, 0, 4'h0, 1, 4'b0000);
        end
        check("R7 pulse ended", irq_n_o, 1);
        // R9: change to minutes with event in write cycle
        cyc(0, 0, 1, 0, 1, 4'b1000, 0, 4'h0);
        cyc(0, 0, 1, 0, 0, 4'h0, 0, 4'h0);
        check("R9 arm after change", flag_o, 0);
        cyc(0, 0, 1, 0, 0, 4'h0, 0, 4'h0);
        check("R9 fires when armed", flag_o, 1);
        // R8 masked
        cyc(0, 0, 0, 0, 1, 4'b1011, 0, 4'h0);
        check("R8 masked irq_n", irq_n_o, 1);
        cyc(0, 0, 0, 0, 1, 4'b1010, 0, 4'h0);
        check("R6 unmask shows flag", irq_n_o, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic cwe;
            logic [3:0] cwd;
            cwe = ($urandom % 40) == 0;
            cwd = 4'($urandom);
            cyc(($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0,
                ($urandom % 9) == 0, cwe, cwd,
                ($urandom % 8) == 0, 4'($urandom));
        end
        idle(P + 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end

endmodule